// File: doc/BRIEF.md
# Nibble-RAM cartridge bank controller

This block sits between an 8-bit CPU with a 16-bit address bus and an external cartridge ROM. CPU reads in the lower half of the address space are turned into an 18-bit ROM address. The first 16 KiB always shows bank 0, and the second 16 KiB shows one of sixteen switchable banks. The controller also holds a 512-entry, 4-bit-wide RAM that the CPU sees at 0xA000-0xA1FF.

Writes to the ROM half of the address space are not stored anywhere in ROM. They are decoded as commands. In 0x0000-0x1FFF, a write with address bit 8 clear turns the RAM on or off. In 0x2000-0x3FFF, a write with address bit 8 set picks the ROM bank. All reads are combinational. Commands and RAM writes take effect at the rising clock edge on which `cpu_wr` is sampled high.

Top module: `nibble_bank_mapper`

## Requirements
- R1: After reset the bank register holds 0 and the RAM is disabled. The switchable window therefore shows bank 1, and RAM reads return 0xFF.
- R2: For a read at 0x0000-0x3FFF, `rom_addr` equals the CPU address with bits 17:14 at zero, and `cpu_rdata` equals `rom_data`.
- R3: For a read at 0x4000-0x7FFF, `rom_addr` is (address − 0x4000) + B × 0x4000, and `cpu_rdata` equals `rom_data`. B is the bank register, except that a bank register value of 0 gives B = 1.
- R4: A write at 0x0000-0x1FFF with address bit 8 clear sets the RAM enable when the data is 0x0A and clears it when the data is 0x00. Any other data value leaves the enable unchanged.
- R5: A write at 0x2000-0x3FFF with address bit 8 set loads the bank register from data bits 3:0. Data bits 7:4 are ignored.
- R6: A write at 0x0000-0x1FFF with address bit 8 set has no effect. A write at 0x2000-0x3FFF with address bit 8 clear has no effect.
- R7: While the RAM is enabled, a write at 0xA000-0xA1FF stores data bits 3:0 at index address[8:0]. A read there returns the stored nibble in bits 3:0, with bits 7:4 at zero.
- R8: While the RAM is disabled, writes at 0xA000-0xA1FF leave the contents unchanged, and reads there return 0xFF.
- R9: `cpu_rdata` is 0xFF when `cpu_rd` is low, and also for reads outside 0x0000-0x7FFF and 0xA000-0xA1FF.
- R10: Writes at 0x4000-0x9FFF and at 0xA200-0xFFFF change neither the bank register, nor the RAM enable, nor the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data to the CPU (combinational) |
| rom_addr | output | 18 | Expanded address to the external ROM |
| rom_data | input | 8 | Data returned by the external ROM |

## Verification
The ROM address and the read data are combinational, so each is due in the same cycle its address is applied. A command or RAM write shows only on reads in the cycles after the rising edge that samples it. The bench changes its inputs on the falling edge and compares both outputs 2 ns later against a behavioural model. At that point the model still holds the state from before the coming edge. The model applies each write only after that edge, so the effect of a write is first checked by the read in the following cycle.

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper #(
  parameter int BANK_W = 4,
  parameter int RAM_AW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_wr,
  input  logic                  cpu_rd,
  output logic [7:0]            cpu_rdata,
  output logic [BANK_W+13:0]    rom_addr,
  input  logic [7:0]            rom_data
);
  localparam int WIN_W     = 14;
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam logic [15-RAM_AW:0] RAM_TAG = 16'hA000 >> RAM_AW;

  logic [BANK_W-1:0] bank_q;
  logic              ram_en_q;
  logic [3:0]        ram_q [RAM_DEPTH];

  logic in_rom, in_ram, ctl_en_hit, ctl_bank_hit, ram_we;
  logic [BANK_W-1:0] bank_eff, bank_sel;
  logic [RAM_AW-1:0] ram_idx;

  assign in_rom       = ~cpu_addr[15];
  assign in_ram       = cpu_addr[15:RAM_AW] == RAM_TAG;
  assign ram_idx      = cpu_addr[RAM_AW-1:0];
  assign ctl_en_hit   = cpu_wr && cpu_addr[15:13] == 3'b000 && !cpu_addr[8];
  assign ctl_bank_hit = cpu_wr && cpu_addr[15:13] == 3'b001 &&  cpu_addr[8];
  assign ram_we       = cpu_wr && in_ram && ram_en_q;

  assign bank_eff = (bank_q == '0) ? BANK_W'(1) : bank_q;
  assign bank_sel = cpu_addr[14] ? bank_eff : '0;
  assign rom_addr = {bank_sel, cpu_addr[WIN_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= '0;
      ram_en_q <= 1'b0;
    end else begin
      if (ctl_en_hit) begin
        if (cpu_wdata == 8'h0A)      ram_en_q <= 1'b1;
        else if (cpu_wdata == 8'h00) ram_en_q <= 1'b0;
      end
      if (ctl_bank_hit) bank_q <= cpu_wdata[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram_q[ram_idx] <= cpu_wdata[3:0];
  end

  always_comb begin
    cpu_rdata = 8'hFF;
    if (cpu_rd) begin
      if (in_rom)                  cpu_rdata = rom_data;
      else if (in_ram && ram_en_q) cpu_rdata = {4'h0, ram_q[ram_idx]};
    end
  end
endmodule

// File: rtl/nibble_bank_mapper_chk.sv
module nibble_bank_mapper_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [7:0]        cpu_rdata,
  input logic [BANK_W+13:0] rom_addr,
  input logic [BANK_W-1:0] bank_q,
  input logic              ram_en_q
);
  logic in_ram_w, en_cmd, bank_cmd;
  assign in_ram_w = cpu_addr >= 16'hA000 && cpu_addr <= 16'hA1FF;
  assign en_cmd   = cpu_wr && cpu_addr < 16'h2000 && !cpu_addr[8]
                    && (cpu_wdata == 8'h0A || cpu_wdata == 8'h00);
  assign bank_cmd = cpu_wr && cpu_addr >= 16'h2000 && cpu_addr < 16'h4000 && cpu_addr[8];

  assert_fixed_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr < 16'h4000 |-> rom_addr == {{BANK_W{1'b0}}, cpu_addr[13:0]});

  assert_switch_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'h4000 && cpu_addr < 16'h8000) |-> rom_addr[BANK_W+13:14] != '0);

  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cmd |=> $stable(ram_en_q));

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_cmd |=> $stable(bank_q));

  assert_bank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd |=> bank_q == $past(cpu_wdata[BANK_W-1:0]));

  assert_ram_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && in_ram_w && ram_en_q) |-> cpu_rdata[7:4] == 4'h0);

  assert_ram_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && in_ram_w && !ram_en_q) |-> cpu_rdata == 8'hFF);

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> cpu_rdata == 8'hFF);
endmodule

bind nibble_bank_mapper nibble_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
  .bank_q(bank_q), .ram_en_q(ram_en_q)
);

// File: tb/nibble_bank_mapper_bench.sv
`timescale 1ns/1ps
module nibble_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [17:0] rom_addr;
  logic [7:0]  rom_data;

  always #10 clk = ~clk;

  assign rom_data = rom_addr[7:0] ^ rom_addr[17:10];

  nibble_bank_mapper u_nibble_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_data(rom_data)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  int   m_bank;
  bit   m_en;
  int   m_mem [512];
  bit   m_val [512];

  function automatic int romf(int a);
    return (a & 'hFF) ^ ((a >> 10) & 'hFF);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) addr=%04h act=%0h exp=%0h", tag, phase, cpu_addr, act, exp);
    end
  endtask

  task automatic cyc(int addr, int data, bit wr, bit rd);
    int eb, erom, a;
    @(negedge clk);
    cpu_addr = 16'(addr); cpu_wdata = 8'(data); cpu_wr = wr; cpu_rd = rd;
    #2;
    a  = addr;
    eb = (m_bank == 0) ? 1 : m_bank;
    if (a < 'h4000) begin
      check("R2", int'(rom_addr), a);
      if (rd) check("R2", int'(cpu_rdata), romf(a));
    end else if (a < 'h8000) begin
      erom = eb * 'h4000 + (a - 'h4000);
      check("R3", int'(rom_addr), erom);
      if (rd) check("R3", int'(cpu_rdata), romf(erom));
    end
    if (!rd) check("R9", int'(cpu_rdata), 'hFF);
    else if (a >= 'hA000 && a <= 'hA1FF) begin
      if (!m_en) check("R8", int'(cpu_rdata), 'hFF);
      else if (m_val[a - 'hA000]) check("R7", int'(cpu_rdata), m_mem[a - 'hA000]);
    end else if (a >= 'h8000) check("R9", int'(cpu_rdata), 'hFF);
    @(posedge clk);
    if (wr) begin
      if (a < 'h2000 && (a & 'h100) == 0) begin
        if (data == 'h0A) m_en = 1;
        else if (data == 'h00) m_en = 0;
      end else if (a >= 'h2000 && a < 'h4000 && (a & 'h100) != 0) m_bank = data & 'hF;
      else if (a >= 'hA000 && a <= 'hA1FF && m_en) begin
        m_mem[a - 'hA000] = data & 'hF;
        m_val[a - 'hA000] = 1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog (phase %s) act=hung exp=finished", phase);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_bank = 0; m_en = 0;
    foreach (m_val[i]) m_val[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state seen through reads
    phase = "R1";
    cyc('h4000, 0, 0, 1);
    cyc('h7ABC, 0, 0, 1);
    cyc('hA000, 0, 0, 1);
    cyc('h1234, 0, 0, 1);
    // R4 / R7: enable, store and read back nibbles
    phase = "R4";
    cyc('h0000, 'h0A, 1, 0);
    cyc('hA005, 'h3C, 1, 0);
    cyc('hA005, 0, 0, 1);
    cyc('hA1FF, 'hF9, 1, 1);
    cyc('hA1FF, 0, 0, 1);
    cyc('h0010, 'h55, 1, 1);
    cyc('hA005, 0, 0, 1);
    // R6: enable range with bit 8 set is ignored
    phase = "R6";
    cyc('h0100, 'h00, 1, 1);
    cyc('hA005, 0, 0, 1);
    phase = "R4";
    cyc('h1EFF, 'h00, 1, 1);
    cyc('hA005, 0, 0, 1);
    // R8: writes while disabled are dropped
    phase = "R8";
    cyc('hA005, 'h07, 1, 1);
    cyc('h0000, 'h0A, 1, 0);
    cyc('hA005, 0, 0, 1);
    // R5 / R3: bank select and bank 0 alias
    phase = "R5";
    cyc('h2100, 'hF3, 1, 0);
    cyc('h4000, 0, 0, 1);
    cyc('h7FFF, 0, 0, 1);
    phase = "R6";
    cyc('h2000, 'h05, 1, 0);
    cyc('h5555, 0, 0, 1);
    phase = "R5";
    cyc('h3F00, 'h0F, 1, 0);
    cyc('h6000, 0, 0, 1);
    phase = "R3";
    cyc('h2100, 'h10, 1, 0);
    cyc('h4001, 0, 0, 1);
    // R10: writes elsewhere leave all state alone
    phase = "R10";
    cyc('h2100, 'h06, 1, 0);
    cyc('h4100, 'h09, 1, 0);
    cyc('h8000, 'h00, 1, 0);
    cyc('hA200, 'h00, 1, 0);
    cyc('hC100, 'h02, 1, 0);
    cyc('h4100, 0, 0, 1);
    cyc('hA005, 0, 0, 1);
    // R9: idle strobe and unmapped reads
    phase = "R9";
    cyc('h1000, 0, 0, 0);
    cyc('hA005, 0, 0, 0);
    cyc('h8000, 0, 0, 1);
    cyc('hA200, 0, 0, 1);
    cyc('hFFFF, 0, 0, 1);
    // mixed traffic across all regions
    phase = "mixed";
    for (int i = 0; i < 4000; i++) begin
      int sel, a;
      sel = $urandom_range(0, 7);
      case (sel)
        0: a = $urandom_range(0, 'h1FFF);
        1: a = $urandom_range('h2000, 'h3FFF);
        2, 3: a = $urandom_range('hA000, 'hA1FF);
        4: a = $urandom_range('h4000, 'h7FFF);
        5: a = $urandom_range('h0000, 'h3FFF);
        default: a = $urandom_range(0, 'hFFFF);
      endcase
      cyc(a, (sel == 0 && $urandom_range(0, 1) == 1) ? ($urandom_range(0, 1) ? 'h0A : 'h00)
                                                      : $urandom_range(0, 255),
          $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule